// File: doc/BRIEF.md
# LSB-First Transaction Frame Assembler

This block sits behind a pulse-width classifier on a single-wire serial bus. The classifier hands it one symbol per accepted cycle: a zero, a one, or a break. Each symbol comes with the timestamps of its falling and rising edges. The assembler counts bit positions and collects the symbols into fixed sixteen-symbol transactions. Each transaction holds a register address, a direction flag and a data byte, and every field is sent least significant bit first.

A break can appear at any point. It throws away whatever partial frame has been collected. When a frame completes, the block raises a single-cycle strobe. During that cycle it presents the direction, address, data and the two timestamps that bound the frame. It then expects a new address at once, without needing a break. The block does not measure pulse widths, does not work out which side drove the bits, and never drives the bus.

Top module: `lsb_frame_assembler`

## Requirements
- R1: Symbol kinds are coded on `sym_kind` as 00 = zero, 01 = one, 10 = break and 11 = reserved. A data symbol (00 or 01) carries bit value `sym_kind[0]`. The first seven data symbols of a frame form `txn_addr`, and the first of them is bit 0.
- R2: The eighth data symbol is the direction flag, reported on `txn_write`: 1 means write and 0 means read.
- R3: The ninth to sixteenth data symbols form `txn_data`, and the ninth symbol is bit 0.
- R4: A break at any bit position, including the last one, discards the partial frame and produces no strobe. The next data symbol is then taken as address bit 0.
- R5: `txn_start` equals the `sym_start` of the first address symbol, and `txn_end` equals the `sym_end` of the sixteenth symbol.
- R6: `txn_valid` is high in the cycle after the sixteenth data symbol is accepted. The following data symbol begins a new frame with no break needed, even when it arrives in that same cycle.
- R7: `txn_valid` is high for exactly one cycle per frame and is low while a frame is still being collected.
- R8: A synchronous reset returns the bit position to zero, clears the partial fields and holds `txn_valid` and all transaction outputs at zero.
- R9: A break while idle, a reserved symbol, and cycles with `sym_valid` low have no effect on the frame being collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | A symbol is presented this cycle |
| sym_kind | input | 2 | Symbol kind: 00 zero, 01 one, 10 break, 11 reserved |
| sym_start | input | TS_W | Timestamp of the symbol's leading edge |
| sym_end | input | TS_W | Timestamp of the symbol's trailing edge |
| txn_valid | output | 1 | One-cycle strobe for a completed transaction |
| txn_write | output | 1 | Direction flag, 1 = write |
| txn_addr | output | ADDR_W | Register address |
| txn_data | output | DATA_W | Data byte |
| txn_start | output | TS_W | Start timestamp of the transaction |
| txn_end | output | TS_W | End timestamp of the transaction |

## Verification
Two events can land on the same clock cycle. The first is the completion strobe of one frame. The second is the acceptance of the first address symbol of the next frame, or of a break that comes right after a completion. The bench provokes this by sending frames back to back, with a symbol on every cycle. It then judges that the strobed fields belong to the finished frame, that the new frame's start timestamp and address are intact, and that the strobe drops after one cycle. A break placed at the last bit position, and a break placed right after a completion, are checked to confirm that each one affects only the partial frame.

// File: rtl/lsb_frame_assembler.sv
module lsb_frame_assembler #(
  parameter int TS_W   = 32,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sym_valid,
  input  logic [1:0]        sym_kind,
  input  logic [TS_W-1:0]   sym_start,
  input  logic [TS_W-1:0]   sym_end,
  output logic              txn_valid,
  output logic              txn_write,
  output logic [ADDR_W-1:0] txn_addr,
  output logic [DATA_W-1:0] txn_data,
  output logic [TS_W-1:0]   txn_start,
  output logic [TS_W-1:0]   txn_end
);
  localparam int FRAME_LEN = ADDR_W + 1 + DATA_W;
  localparam int POS_W     = $clog2(FRAME_LEN + 1);
  localparam logic [POS_W-1:0] DIR_POS  = POS_W'(ADDR_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0]  pos;
  logic [ADDR_W-1:0] addr_sr;
  logic [DATA_W-1:0] data_sr;
  logic              dir_q;
  logic [TS_W-1:0]   start_q;

  wire is_data  = sym_valid && !sym_kind[1];
  wire is_break = sym_valid && (sym_kind == 2'b10);
  wire bit_v    = sym_kind[0];
  wire at_first = (pos == '0);
  wire in_addr  = (pos < DIR_POS);
  wire at_dir   = (pos == DIR_POS);
  wire at_last  = (pos == LAST_POS);

  wire [DATA_W-1:0] data_next = {bit_v, data_sr[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= '0;
      addr_sr   <= '0;
      data_sr   <= '0;
      dir_q     <= 1'b0;
      start_q   <= '0;
      txn_valid <= 1'b0;
      txn_write <= 1'b0;
      txn_addr  <= '0;
      txn_data  <= '0;
      txn_start <= '0;
      txn_end   <= '0;
    end else begin
      txn_valid <= 1'b0;
      if (is_break) begin
        pos     <= '0;
        addr_sr <= '0;
        data_sr <= '0;
        dir_q   <= 1'b0;
      end else if (is_data) begin
        if (at_first) start_q <= sym_start;
        if (in_addr)     addr_sr <= {bit_v, addr_sr[ADDR_W-1:1]};
        else if (at_dir) dir_q   <= bit_v;
        else             data_sr <= data_next;
        if (at_last) begin
          pos       <= '0;
          txn_valid <= 1'b1;
          txn_write <= dir_q;
          txn_addr  <= addr_sr;
          txn_data  <= data_next;
          txn_start <= start_q;
          txn_end   <= sym_end;
          addr_sr   <= '0;
          data_sr   <= '0;
          dir_q     <= 1'b0;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lsb_frame_assembler_chk.sv
module lsb_frame_assembler_chk #(
  parameter int TS_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            sym_valid,
  input logic [1:0]      sym_kind,
  input logic [TS_W-1:0] sym_end,
  input logic            txn_valid,
  input logic [TS_W-1:0] txn_end
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    txn_valid |=> !txn_valid); // R7
  AST_BREAK_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_kind == 2'b10) |=> !txn_valid); // R4
  AST_RESERVED_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && sym_kind == 2'b11) |=> !txn_valid); // R9
  AST_STROBE_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> $past(sym_valid && !sym_kind[1])); // R6
  AST_END_STAMP: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> (txn_end == $past(sym_end))); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !txn_valid); // R8
endmodule

bind lsb_frame_assembler lsb_frame_assembler_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_kind(sym_kind),
  .sym_end(sym_end), .txn_valid(txn_valid), .txn_end(txn_end)
);

// File: tb/test_lsb_frame_assembler.sv
module test_lsb_frame_assembler;
  localparam int TS_W = 32;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_valid = 1'b0;
  logic [1:0] sym_kind = 2'b00;
  logic [TS_W-1:0] sym_start = '0, sym_end = '0;
  logic txn_valid, txn_write;
  logic [6:0] txn_addr;
  logic [7:0] txn_data;
  logic [TS_W-1:0] txn_start, txn_end;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  lsb_frame_assembler #(.TS_W(TS_W)) i_lsb_frame_assembler (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_kind(sym_kind),
    .sym_start(sym_start), .sym_end(sym_end), .txn_valid(txn_valid),
    .txn_write(txn_write), .txn_addr(txn_addr), .txn_data(txn_data),
    .txn_start(txn_start), .txn_end(txn_end)
  );

  // {gap, dir, addr[6:0], data[7:0]}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 1'b1, 7'h00, 8'h00},
    {1'b1, 1'b1, 7'h7F, 8'hFF},
    {1'b0, 1'b0, 7'h55, 8'hA5},
    {1'b1, 1'b1, 7'h2A, 8'h5A},
    {1'b0, 1'b0, 7'h01, 8'h80},
    {1'b0, 1'b1, 7'h40, 8'h01}
  };

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic send_sym(input logic [1:0] kind, input logic [TS_W-1:0] st, input logic [TS_W-1:0] en, input bit gap);
    sym_valid = 1'b1; sym_kind = kind; sym_start = st; sym_end = en;
    @(posedge clk); @(negedge clk);
    sym_valid = 1'b0;
    if (gap) begin @(posedge clk); @(negedge clk); end
  endtask

  function automatic logic [15:0] frame_bits(input logic dir, input logic [6:0] a, input logic [7:0] d);
    return {d, dir, a};
  endfunction

  // Sends symbols [0, upto) of a frame; checks strobe stays low after each (R7)
  task automatic send_part(input logic dir, input logic [6:0] a, input logic [7:0] d,
                           input logic [TS_W-1:0] base, input int upto, input bit gap);
    logic [15:0] fb;
    fb = frame_bits(dir, a, d);
    for (int i = 0; i < upto; i++) begin
      send_sym({1'b0, fb[i]}, base + TS_W'(i * 10), base + TS_W'(i * 10 + 5), gap && (i != 15));
      if (i != 15) check(txn_valid == 1'b0, "R7 strobe low mid-frame", 80'(txn_valid), 80'(0));
    end
  endtask

  task automatic expect_txn(input logic dir, input logic [6:0] a, input logic [7:0] d,
                            input logic [TS_W-1:0] base, input string req);
    logic [79:0] act, exp;
    act = {txn_valid, txn_write, txn_addr, txn_data, txn_start, txn_end[30:0]};
    exp = {1'b1, dir, a, d, base, 31'(base + 155)};
    check(act == exp && txn_end == base + 155, req, act, exp);
  endtask

  task automatic full_frame(input logic dir, input logic [6:0] a, input logic [7:0] d,
                            input logic [TS_W-1:0] base, input bit gap, input string req);
    send_part(dir, a, d, base, 16, gap);
    expect_txn(dir, a, d, base, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    check({txn_valid, txn_write, txn_addr, txn_data, txn_start, txn_end} == '0, "R8 reset state",
          {txn_valid, txn_write, txn_addr, txn_data, txn_start[31:0], txn_end[31:0]}, 80'(0));
    rst = 1'b0;
    @(negedge clk);

    // Vector table: R1 R2 R3 R5 R6 (gap entries exercise R9 idle cycles)
    for (int k = 0; k < 6; k++) begin
      full_frame(VEC[k][15], VEC[k][14:8], VEC[k][7:0], TS_W'(1000 * (k + 1)), VEC[k][16],
                 "R1 R2 R3 R5 R6 table frame");
    end
    @(posedge clk); @(negedge clk);
    check(txn_valid == 1'b0, "R7 strobe drops after one cycle", 80'(txn_valid), 80'(0));

    // R4: break mid-frame, then a new frame
    send_part(1'b1, 7'h33, 8'hCC, 32'd20000, 10, 1'b0);
    send_sym(2'b10, 32'd20100, 32'd20300, 1'b0);
    check(txn_valid == 1'b0, "R4 no strobe on break", 80'(txn_valid), 80'(0));
    full_frame(1'b0, 7'h12, 8'h34, 32'd21000, 1'b0, "R4 frame after mid break");

    // R4: break at last position
    send_part(1'b1, 7'h7E, 8'h7E, 32'd22000, 15, 1'b0);
    send_sym(2'b10, 32'd22150, 32'd22350, 1'b0);
    check(txn_valid == 1'b0, "R4 break at last position", 80'(txn_valid), 80'(0));
    full_frame(1'b1, 7'h6B, 8'h3C, 32'd23000, 1'b0, "R4 frame after late break");

    // R9: break right after completion (idle), then a frame
    send_sym(2'b10, 32'd23500, 32'd23700, 1'b0);
    check(txn_valid == 1'b0, "R9 idle break no strobe", 80'(txn_valid), 80'(0));
    send_sym(2'b10, 32'd23800, 32'd24000, 1'b1);
    full_frame(1'b0, 7'h3F, 8'hE1, 32'd24000, 1'b0, "R9 frame after idle breaks");

    // R9: reserved symbols inside a frame are ignored
    send_part(1'b1, 7'h5C, 8'h96, 32'd25000, 8, 1'b0);
    send_sym(2'b11, 32'd1, 32'd2, 1'b0);
    check(txn_valid == 1'b0, "R9 reserved no strobe", 80'(txn_valid), 80'(0));
    begin
      logic [15:0] fb;
      fb = frame_bits(1'b1, 7'h5C, 8'h96);
      for (int i = 8; i < 16; i++) begin
        send_sym({1'b0, fb[i]}, 32'd25000 + TS_W'(i * 10), 32'd25000 + TS_W'(i * 10 + 5), 1'b0);
        if (i == 11) send_sym(2'b11, 32'd3, 32'd4, 1'b0);
      end
    end
    expect_txn(1'b1, 7'h5C, 8'h96, 32'd25000, "R9 reserved ignored");

    // R8: reset mid-frame
    send_part(1'b1, 7'h7F, 8'hFF, 32'd26000, 5, 1'b0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(txn_valid == 1'b0 && txn_addr == '0, "R8 reset clears outputs",
          {txn_valid, txn_addr}, 80'(0));
    rst = 1'b0;
    full_frame(1'b0, 7'h08, 8'h10, 32'd27000, 1'b0, "R8 frame after reset");
    @(posedge clk); @(negedge clk);
    check(txn_valid == 1'b0, "R7 final strobe one cycle", 80'(txn_valid), 80'(0));

    report();
  end
endmodule